// File: doc/BRIEF.md
# Spectral Component Synthesizer with Randomizer

For each input of a combinational circuit under test, this block produces one test bit per BIST clock. A lane builds its bit from the Walsh function bus, choosing one, two or three of its wires. Those components are time-shared in fixed proportions, with the choice steered by weight-0.5 random bits. The chosen component bit is then XORed with a weighted random noise bit, so that the stream holds the main spectral content while gaining extra fault detection from the noise. The Walsh bus and the weighted random bits come from generators outside this block.

The per-lane configuration forms the seed. The seed holds the component indices, the component count and a noise enable for every lane. It is loaded from a tester either in parallel in one cycle or serially through a scan chain. In tester mode each load yields exactly one vector. In hybrid mode each load yields a programmed number of vectors, and the block then waits for the next reseed. During load cycles generation pauses and the outputs hold their value.

Top module: `spec_synth`

## Requirements
- R1: After reset, test_o is all zero, vec_o is 0 and the seed is all zero, so scan_o is 0.
- R2: A lane whose component-count field is 0 or 1 outputs its first component, walsh_i[idx0], before noise is applied.
- R3: A lane with count 2 uses walsh_i[idx1] when its steering bit sel_rnd_i[2i] is 1, and walsh_i[idx0] otherwise, giving a 0.5/0.5 split.
- R4: A lane with count 3 uses walsh_i[idx2] when sel_rnd_i[2i] is 1. Otherwise it uses walsh_i[idx1] when sel_rnd_i[2i+1] is 1, and walsh_i[idx0] when it is 0. This gives a 0.25/0.25/0.5 split.
- R5: The lane bit is the component XOR (noise_en AND noise_rnd_i[i]). When noise_en is 0 the noise input has no effect.
- R6: Lane i occupies seed bits [i*LANE_W +: LANE_W], where LANE_W = 3*HAD_ORDER+3. Inside a lane, idx0 sits at [H-1:0], idx1 at [2H-1:H] and idx2 at [3H-1:2H]. The count field is at [3H+1:3H] and noise_en at [3H+2], with H = HAD_ORDER.
- R7: When ld_par_i is high, seed_par_i is copied into the seed. This takes priority over a serial shift in the same cycle.
- R8: When ld_ser_i is high and ld_par_i is low, the seed shifts right with scan_i entering the MSB, and scan_o is the seed LSB. After SEED_W shifts, the first bit shifted in sits at bit 0.
- R9: A cycle with ld_par_i or ld_ser_i high is a load cycle. In it test_o is held and no vec_o pulse follows.
- R10: When mode_i is 0 (tester mode), each load is followed by exactly one generated vector, after which test_o holds.
- R11: When mode_i is 1 (hybrid mode), each load is followed by interval_i generated vectors, with interval_i sampled at the load. After that test_o holds. An interval of 0 yields no vector.
- R12: On a generating edge, test_o takes the lane bits computed from that cycle's inputs, and vec_o is 1 for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | BIST clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 tester mode, 1 hybrid mode |
| interval_i | input | CNT_W | Vectors per reseed in hybrid mode |
| walsh_i | input | 2**HAD_ORDER | Walsh function bus |
| sel_rnd_i | input | 2*NUM_IN | Weight-0.5 steering bits, two per lane |
| noise_rnd_i | input | NUM_IN | Weighted noise bits, one per lane |
| ld_par_i | input | 1 | Parallel seed load |
| seed_par_i | input | SEED_W | Parallel seed value |
| ld_ser_i | input | 1 | Serial seed shift enable |
| scan_i | input | 1 | Serial seed data in |
| scan_o | output | 1 | Serial seed data out (seed LSB) |
| test_o | output | NUM_IN | Test bits to the circuit under test |
| vec_o | output | 1 | New vector presented on test_o |

## Verification
A fixed seed gives the four lanes different mixes: a clean single component, two components with noise, three components with noise, and a single component whose count field is zero. A table of Walsh, steering and noise patterns is then applied and compared with a reference model. Each steering pattern tells apart which component a lane picked, and noise patterns with a lane's enable clear show that the noise is blocked. Directed sequences cover the vector counts after a load in both modes, the hold during parallel and serial loads, and parallel-over-serial priority. They also cover scan-out of the previous seed during shifting and an interval of zero.

// File: rtl/spec_synth_pkg.sv
package spec_synth_pkg;
  typedef enum logic {MODE_TESTER = 1'b0, MODE_HYBRID = 1'b1} gen_mode_e;
  typedef enum logic [1:0] {
    NC_ZERO  = 2'd0,
    NC_ONE   = 2'd1,
    NC_TWO   = 2'd2,
    NC_THREE = 2'd3
  } ncomp_e;
endpackage

// File: rtl/spec_lane.sv
module spec_lane
  import spec_synth_pkg::*;
#(
  parameter int unsigned HAD_ORDER = 3,
  localparam int unsigned NW     = 1 << HAD_ORDER,
  localparam int unsigned LANE_W = 3 * HAD_ORDER + 3
) (
  input  logic [LANE_W-1:0] cfg_i,
  input  logic [NW-1:0]     walsh_i,
  input  logic [1:0]        sel_i,
  input  logic              noise_i,
  output logic              bit_o
);
  localparam int unsigned H = HAD_ORDER;

  logic [H-1:0] idx0, idx1, idx2;
  ncomp_e       ncomp;
  logic         noise_en;
  logic         comp;

  assign idx0     = cfg_i[H-1:0];
  assign idx1     = cfg_i[2*H-1:H];
  assign idx2     = cfg_i[3*H-1:2*H];
  assign ncomp    = ncomp_e'(cfg_i[3*H+1:3*H]);
  assign noise_en = cfg_i[3*H+2];

  // steering: sel_i[0] takes half the slots, sel_i[1] splits the rest
  always_comb begin
    unique case (ncomp)
      NC_TWO:   comp = sel_i[0] ? walsh_i[idx1] : walsh_i[idx0];
      NC_THREE: comp = sel_i[0] ? walsh_i[idx2]
                                : (sel_i[1] ? walsh_i[idx1] : walsh_i[idx0]);
      default:  comp = walsh_i[idx0];
    endcase
  end

  assign bit_o = comp ^ (noise_en & noise_i);
endmodule

// File: rtl/spec_seed_reg.sv
module spec_seed_reg #(
  parameter int unsigned SEED_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_par_i,
  input  logic [SEED_W-1:0] par_i,
  input  logic              ld_ser_i,
  input  logic              ser_i,
  output logic [SEED_W-1:0] seed_o,
  output logic              ser_o
);
  logic [SEED_W-1:0] seed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seed_q <= '0;
    else if (ld_par_i) seed_q <= par_i;
    else if (ld_ser_i) seed_q <= {ser_i, seed_q[SEED_W-1:1]};
  end

  assign seed_o = seed_q;
  assign ser_o  = seed_q[0];

  a_r7_par_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_par_i |=> seed_q == $past(par_i));
  a_r8_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ser_i && !ld_par_i) |=> ser_o == $past(seed_q[1]));
  a_r8_idle_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ser_i && !ld_par_i) |=> $stable(seed_q));
endmodule

// File: rtl/spec_gen_ctrl.sv
module spec_gen_ctrl
  import spec_synth_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             gen_o
);
  logic [CNT_W-1:0] budget_q;

  assign gen_o = !load_i && (budget_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) budget_q <= '0;
    else if (load_i)
      budget_q <= (gen_mode_e'(mode_i) == MODE_HYBRID) ? interval_i : CNT_W'(1);
    else if (gen_o)
      budget_q <= budget_q - CNT_W'(1);
  end

  a_r11_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> budget_q <= $past(budget_q));
  a_r10_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && gen_mode_e'(mode_i) == MODE_TESTER) |=> (gen_o || load_i) |=> !gen_o || $past(load_i));
endmodule

// File: rtl/spec_synth.sv
module spec_synth
  import spec_synth_pkg::*;
#(
  parameter int unsigned NUM_IN    = 4,
  parameter int unsigned HAD_ORDER = 3,
  parameter int unsigned CNT_W     = 8,
  localparam int unsigned NW     = 1 << HAD_ORDER,
  localparam int unsigned LANE_W = 3 * HAD_ORDER + 3,
  localparam int unsigned SEED_W = NUM_IN * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  interval_i,
  input  logic [NW-1:0]     walsh_i,
  input  logic [2*NUM_IN-1:0] sel_rnd_i,
  input  logic [NUM_IN-1:0] noise_rnd_i,
  input  logic              ld_par_i,
  input  logic [SEED_W-1:0] seed_par_i,
  input  logic              ld_ser_i,
  input  logic              scan_i,
  output logic              scan_o,
  output logic [NUM_IN-1:0] test_o,
  output logic              vec_o
);
  logic [SEED_W-1:0] seed;
  logic [NUM_IN-1:0] mix;
  logic              load, gen;
  logic [NUM_IN-1:0] test_q;
  logic              vec_q;

  assign load = ld_par_i | ld_ser_i;

  spec_seed_reg #(.SEED_W(SEED_W)) u_seed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_par_i(ld_par_i),
    .par_i   (seed_par_i),
    .ld_ser_i(ld_ser_i),
    .ser_i   (scan_i),
    .seed_o  (seed),
    .ser_o   (scan_o)
  );

  spec_gen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .mode_i    (mode_i),
    .interval_i(interval_i),
    .gen_o     (gen)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    spec_lane #(.HAD_ORDER(HAD_ORDER)) u_lane (
      .cfg_i  (seed[i*LANE_W +: LANE_W]),
      .walsh_i(walsh_i),
      .sel_i  (sel_rnd_i[2*i +: 2]),
      .noise_i(noise_rnd_i[i]),
      .bit_o  (mix[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q <= '0;
      vec_q  <= 1'b0;
    end else begin
      vec_q <= gen;
      if (gen) test_q <= mix;
    end
  end

  assign test_o = test_q;
  assign vec_o  = vec_q;

  a_r9_hold_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> $stable(test_o));
  a_r9_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !vec_o);
  a_r12_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_o |-> $stable(test_o));
endmodule

// File: tb/tb_spec_synth.sv
module tb_spec_synth;
  localparam int NUM_IN = 4;
  localparam int H      = 3;
  localparam int CNT_W  = 8;
  localparam int NW     = 1 << H;
  localparam int LANE_W = 3 * H + 3;
  localparam int SEED_W = NUM_IN * LANE_W;

  // lane3..lane0, fields per R6
  localparam logic [SEED_W-1:0] SEED_A = 48'h803_FD4_C31_205;
  localparam logic [SEED_W-1:0] SEED_B = 48'hF61_41E_A07_688;

  // {walsh[7:0], sel[7:0], noise[3:0]}
  localparam logic [19:0] STIM [12] = '{
    {8'hA5, 8'h00, 4'h0}, {8'h5A, 8'hFF, 4'h0}, {8'hF0, 8'h55, 4'hF},
    {8'h0F, 8'hAA, 4'h5}, {8'hCC, 8'h11, 4'hA}, {8'h33, 8'h22, 4'h3},
    {8'h96, 8'h44, 4'hC}, {8'h69, 8'h88, 4'h6}, {8'hFF, 8'h5A, 4'h9},
    {8'h00, 8'hA5, 4'hF}, {8'h3C, 8'h0F, 4'h1}, {8'hC3, 8'hF0, 4'h8}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mode_i = 1'b0;
  logic [CNT_W-1:0]  interval_i = '0;
  logic [NW-1:0]     walsh_i = '0;
  logic [2*NUM_IN-1:0] sel_rnd_i = '0;
  logic [NUM_IN-1:0] noise_rnd_i = '0;
  logic              ld_par_i = 1'b0;
  logic [SEED_W-1:0] seed_par_i = '0;
  logic              ld_ser_i = 1'b0;
  logic              scan_i = 1'b0;
  logic              scan_o;
  logic [NUM_IN-1:0] test_o;
  logic              vec_o;

  int checks = 0;
  int failures = 0;

  spec_synth #(.NUM_IN(NUM_IN), .HAD_ORDER(H), .CNT_W(CNT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .interval_i(interval_i),
    .walsh_i(walsh_i), .sel_rnd_i(sel_rnd_i), .noise_rnd_i(noise_rnd_i),
    .ld_par_i(ld_par_i), .seed_par_i(seed_par_i), .ld_ser_i(ld_ser_i),
    .scan_i(scan_i), .scan_o(scan_o), .test_o(test_o), .vec_o(vec_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [NUM_IN-1:0] model(input logic [SEED_W-1:0] s,
                                              input logic [19:0] st);
    logic [NUM_IN-1:0] r;
    logic [NW-1:0] w;
    logic [2*NUM_IN-1:0] sl;
    logic [NUM_IN-1:0] nz;
    w = st[19:12]; sl = st[11:4]; nz = st[3:0];
    for (int i = 0; i < NUM_IN; i++) begin
      logic [LANE_W-1:0] c;
      logic comp;
      c = s[i*LANE_W +: LANE_W];
      case (c[10:9])
        2'd2: comp = sl[2*i] ? w[c[5:3]] : w[c[2:0]];                     // R3
        2'd3: comp = sl[2*i] ? w[c[8:6]] : (sl[2*i+1] ? w[c[5:3]] : w[c[2:0]]); // R4
        default: comp = w[c[2:0]];                                        // R2
      endcase
      r[i] = comp ^ (c[11] & nz[i]);                                      // R5
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [19:0] st);
    @(negedge clk_i);
    ld_par_i = 1'b0; ld_ser_i = 1'b0;
    walsh_i = st[19:12]; sel_rnd_i = st[11:4]; noise_rnd_i = st[3:0];
    @(posedge clk_i); #2;
  endtask

  task automatic par_load(input logic [SEED_W-1:0] s, input logic m,
                          input logic [CNT_W-1:0] iv, input logic also_ser);
    @(negedge clk_i);
    ld_par_i = 1'b1; seed_par_i = s; mode_i = m; interval_i = iv;
    ld_ser_i = also_ser; scan_i = 1'b1;
    walsh_i = ~walsh_i; noise_rnd_i = ~noise_rnd_i;
    @(posedge clk_i); #2;
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NUM_IN-1:0] held;
    logic [19:0] st;
    int bad;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk("R1 test_o", 64'(test_o), 64'd0);
    chk("R1 vec_o", 64'(vec_o), 64'd0);
    chk("R1 scan_o", 64'(scan_o), 64'd0);

    // hybrid, 14 vectors
    par_load(SEED_A, 1'b1, 8'd14, 1'b0);
    chk("R9 load hold test_o", 64'(test_o), 64'd0);
    chk("R9 load no vec", 64'(vec_o), 64'd0);
    foreach (STIM[k]) begin
      drive(STIM[k]);
      chk("R2 R3 R4 R5 R6 R12 table", 64'(test_o), 64'(model(SEED_A, STIM[k])));
      chk("R12 vec pulse", 64'(vec_o), 64'd1);
    end
    for (int k = 0; k < 2; k++) begin
      st = STIM[k] ^ 20'h0000F;
      drive(st);
      chk("R11 tail vectors", 64'(test_o), 64'(model(SEED_A, st)));
    end
    held = test_o;
    drive(20'hFFF5F);
    chk("R11 hold after interval", 64'(test_o), 64'(held));
    chk("R11 no vec after interval", 64'(vec_o), 64'd0);

    // tester mode: one vector, noise blocked on lane0
    par_load(SEED_A, 1'b0, 8'd50, 1'b0);
    st = {8'h20, 8'h00, 4'hF};
    drive(st);
    chk("R10 one vector", 64'(test_o), 64'(model(SEED_A, st)));
    chk("R5 noise ignored lane0", 64'(test_o[0]), 64'd1);
    held = test_o;
    drive(20'h5A_A5_A);
    chk("R10 hold after one", 64'(test_o), 64'(held));
    chk("R10 no second vec", 64'(vec_o), 64'd0);

    // parallel wins over serial, hybrid 3
    par_load(SEED_B, 1'b1, 8'd3, 1'b1);
    drive(STIM[2]);
    chk("R7 par priority", 64'(test_o), 64'(model(SEED_B, STIM[2])));
    held = test_o;
    par_load(SEED_B, 1'b1, 8'd3, 1'b0);
    chk("R9 mid-run load hold", 64'(test_o), 64'(held));
    chk("R9 mid-run no vec", 64'(vec_o), 64'd0);
    for (int k = 3; k < 6; k++) begin
      drive(STIM[k]);
      chk("R11 reload count", 64'(test_o), 64'(model(SEED_B, STIM[k])));
    end
    held = test_o;
    drive(STIM[6]);
    chk("R11 reload exhausted", 64'(test_o), 64'(held));

    // serial load of SEED_A, tester mode
    held = test_o;
    bad = 0;
    mode_i = 1'b0;
    for (int k = 0; k < SEED_W; k++) begin
      @(negedge clk_i);
      ld_par_i = 1'b0; ld_ser_i = 1'b1; scan_i = SEED_A[k];
      walsh_i = walsh_i + 8'd37; noise_rnd_i = ~noise_rnd_i;
      #1;
      if (scan_o !== SEED_B[k]) bad++;
      if (test_o !== held || vec_o !== 1'b0) bad++;
    end
    @(posedge clk_i); #2;
    chk("R8 scan out old seed", 64'(bad), 64'd0);
    chk("R9 hold during shift", 64'(test_o), 64'(held));
    chk("R8 scan_o lsb", 64'(scan_o), 64'(SEED_A[0]));
    drive(STIM[7]);
    chk("R8 R10 serial seed used", 64'(test_o), 64'(model(SEED_A, STIM[7])));

    // hybrid interval zero
    held = test_o;
    par_load(SEED_B, 1'b1, 8'd0, 1'b0);
    drive(STIM[8]);
    chk("R11 zero interval hold", 64'(test_o), 64'(held));
    chk("R11 zero interval no vec", 64'(vec_o), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule